// File: doc/BRIEF.md
# Programmable-Length Video Line Delay

This block delays a stream of 12-bit pixels by a number of clock cycles chosen at run time. Every word presented on the input is captured in an input register, written into a circular store of 2^ADDR_W words (4096 by default), and read back into an output register. The user loads a length value L into a length register. The delay from input to output is then L+2 cycles. The store wraps after L+1 locations, not after its full depth.

Two active-low strobes return the write pointer and the read pointer to location 0. Both strobes must be low in the same cycle (a "sync reset") before the delay relationship holds. That same cycle is also the only moment at which a newly loaded length becomes active.

A recirculate input freezes the write pointer and discards incoming pixels. The read pointer keeps moving, so the last L+1 stored words play back as a loop. An output-enable input and a valid flag gate the output word.

A control state machine tracks whether the output can be trusted. Its states are:
- ST_IDLE: after power-up, no sync reset seen yet.
- ST_FILL: counting out one full delay after a sync reset.
- ST_RUN: normal valid delay.
- ST_LOOP: valid playback in recirculate mode.
- ST_STALE: the pointer relationship is broken.

Its transitions are:
- T_SYNC: both strobes low, from any state to ST_FILL.
- T_SPLIT: exactly one strobe low, from any state to ST_STALE.
- T_FILLED: from ST_FILL to ST_RUN, when the count reaches L+1.
- T_BREAK: from ST_FILL to ST_STALE, when recirculate is raised during the fill.
- T_FREEZE: from ST_RUN to ST_LOOP, when recirculate is raised.
- T_THAW: from ST_LOOP to ST_STALE, when recirculate is dropped.

Top module: `line_delay`

## Requirements
- R1: After `rst_n` is released and before any sync reset (both `rst_wr_n` and `rst_rd_n` low on one edge), `dout_valid` is 0 and `dout` is 0.
- R2: In normal operation with active length L, the word sampled on `din` at clock edge k appears on `dout` right after edge k+L+2.
- R3: After a sync reset on edge E0, `dout_valid` is 0 up to and including edge E0+L+1. It becomes 1 right after edge E0+L+2, and the first valid word is the one sampled at E0.
- R4: `len_in` is stored on a rising edge with `len_ld_n` low. A stored value takes over the active length only on a sync-reset edge, and a load on that same edge is the one used. Until then, the delay and `dout_valid` are unchanged.
- R5: While `recirc` is 1, no word is written and `din` is ignored. If recirculate is entered at edge T from valid operation, the output after edge T+j is the word sampled at edge T-L-2+(j mod (L+1)), with `dout_valid` held at 1.
- R6: Dropping `recirc` without a sync reset drives `dout_valid` to 0 after that edge, and it stays 0 until the next sync reset.
- R7: An edge with exactly one of `rst_wr_n`/`rst_rd_n` low sets that pointer to location 0 and drives `dout_valid` to 0 until the next sync reset.
- R8: `dout` equals the stored word only while `dout_valid` is 1 and `oe_n` is 0; otherwise it is 0. `oe_n` acts on `dout` combinationally and does not change `dout_valid`.
- R9: The length limits work: L=0 gives a delay of 2, and L=2^ADDR_W-1 gives a delay of 2^ADDR_W+1.
- R10: Raising `recirc` during the fill after a sync reset drives `dout_valid` to 0 until the next sync reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| din | input | DATA_W | Pixel input, registered |
| len_in | input | ADDR_W | Length value L, delay = L+2 |
| len_ld_n | input | 1 | Active-low load strobe for the length register |
| recirc | input | 1 | 1 = recirculate (loop playback), 0 = delay |
| rst_wr_n | input | 1 | Active-low write-pointer reset |
| rst_rd_n | input | 1 | Active-low read-pointer reset |
| oe_n | input | 1 | Active-low output enable |
| dout | output | DATA_W | Delayed pixel, zero when not valid or not enabled |
| dout_valid | output | 1 | Output word is a real delayed sample |

## Verification
The two functions that can fall in the same cycle are a length load and a sync reset. The bench provokes this collision for every length 0..31 of a 32-word configuration, by pulling `len_ld_n` and both pointer strobes low on the same edge. It then judges, edge by edge, that the delay and the rise of `dout_valid` follow the value loaded in that edge, not the previously stored one. The opposite case is also driven: a load without a reset must leave the running delay unchanged until a later reset with no load applies it.

// File: rtl/line_delay_pkg.sv
package line_delay_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_RUN,
        ST_LOOP,
        ST_STALE
    } ld_state_e;

endpackage

// File: rtl/line_delay_ptr.sv
// Circular address counter that wraps after location lim.
module line_delay_ptr #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          adv,
    input  logic [AW-1:0] lim,
    output logic [AW-1:0] ptr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (!clr_n) begin
            ptr <= '0;
        end else if (adv) begin
            if (ptr >= lim) ptr <= '0;
            else            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/line_delay_ram.sv
// Simple dual-port store; a read and a write to the same address in one edge returns the old word.
module line_delay_ram #(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        rdata <= store[raddr];
        if (we) store[waddr] <= wdata;
    end

endmodule

// File: rtl/line_delay_ctrl.sv
// Length registers and the output-validity state machine.
module line_delay_ctrl
    import line_delay_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          recirc,
    input  logic          clr_wr_n,
    input  logic          clr_rd_n,
    input  logic [AW-1:0] len_in,
    input  logic          len_ld_n,
    output logic [AW-1:0] lim_act,
    output logic          valid_q
);

    localparam int CW = AW + 1;

    ld_state_e     state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [CW-1:0] fill_end;
    logic [AW-1:0] len_q;
    logic          sync_clr, split_clr;

    assign sync_clr  = !clr_wr_n && !clr_rd_n;
    assign split_clr = clr_wr_n ^ clr_rd_n;
    assign fill_end  = CW'(lim_act) + CW'(1);

    // length storage: staged value and active value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            lim_act <= '0;
        end else begin
            if (!len_ld_n) len_q <= len_in;
            if (sync_clr)  lim_act <= (!len_ld_n) ? len_in : len_q;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (sync_clr) begin
            state_n = ST_FILL;                    // T_SYNC
            cnt_n   = '0;
        end else if (split_clr) begin
            state_n = ST_STALE;                   // T_SPLIT
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_n = ST_IDLE;
                end
                ST_FILL: begin
                    if (recirc)               state_n = ST_STALE;   // T_BREAK
                    else if (cnt == fill_end) state_n = ST_RUN;     // T_FILLED
                    else                      cnt_n   = cnt + 1'b1;
                end
                ST_RUN: begin
                    if (recirc) state_n = ST_LOOP;                  // T_FREEZE
                end
                ST_LOOP: begin
                    if (!recirc) state_n = ST_STALE;                // T_THAW
                end
                ST_STALE: begin
                    state_n = ST_STALE;
                end
                default: begin
                    state_n = ST_STALE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // output register, aligned with the store's read register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= (state_n == ST_RUN) || (state_n == ST_LOOP);
    end

endmodule

// File: rtl/line_delay.sv
module line_delay #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] len_in,
    input  logic              len_ld_n,
    input  logic              recirc,
    input  logic              rst_wr_n,
    input  logic              rst_rd_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);

    localparam int NPTR = 2;   // index 0 = write, 1 = read

    logic [DATA_W-1:0] din_q;
    logic [DATA_W-1:0] rd_word;
    logic [ADDR_W-1:0] lim_act;
    logic [ADDR_W-1:0] ptr_q [NPTR];
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic              wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= din;
    end

    genvar g;
    generate
        for (g = 0; g < NPTR; g++) begin : g_ptr
            line_delay_ptr #(.AW(ADDR_W)) u_ptr (
                .clk   (clk),
                .rst_n (rst_n),
                .clr_n ((g == 0) ? rst_wr_n : rst_rd_n),
                .adv   ((g == 0) ? !recirc : 1'b1),
                .lim   (lim_act),
                .ptr   (ptr_q[g])
            );
        end
    endgenerate

    assign wr_ptr = ptr_q[0];
    assign rd_ptr = ptr_q[1];
    assign wr_en  = !recirc && rst_wr_n;

    line_delay_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (din_q),
        .raddr (rd_ptr),
        .rdata (rd_word)
    );

    line_delay_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .recirc   (recirc),
        .clr_wr_n (rst_wr_n),
        .clr_rd_n (rst_rd_n),
        .len_in   (len_in),
        .len_ld_n (len_ld_n),
        .lim_act  (lim_act),
        .valid_q  (dout_valid)
    );

    assign dout = (dout_valid && !oe_n) ? rd_word : '0;

endmodule

// File: rtl/line_delay_chk.sv
module line_delay_chk #(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          recirc,
    input logic          rst_wr_n,
    input logic          rst_rd_n,
    input logic          len_ld_n,
    input logic [AW-1:0] len_in,
    input logic          oe_n,
    input logic [DW-1:0] dout,
    input logic          dout_valid,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] lim_act
);

    // R3
    sync_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_wr_n && !rst_rd_n) |=> !dout_valid);

    // R3
    no_instant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_valid) |-> $past(rst_wr_n && rst_rd_n));

    // R4
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_wr_n || rst_rd_n) |=> $stable(lim_act));

    // R4
    len_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_wr_n && !rst_rd_n && !len_ld_n) |=> (lim_act == $past(len_in)));

    // R5
    wr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (recirc && rst_wr_n) |=> $stable(wr_ptr));

    // R6
    thaw_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!recirc && $past(recirc) && rst_wr_n && rst_rd_n) |=> !dout_valid);

    // R7
    split_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_wr_n != rst_rd_n) |=> !dout_valid);

    // R7
    wr_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_wr_n |=> (wr_ptr == '0));

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || !dout_valid) |-> (dout == '0));

endmodule

bind line_delay line_delay_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .recirc     (recirc),
    .rst_wr_n   (rst_wr_n),
    .rst_rd_n   (rst_rd_n),
    .len_ld_n   (len_ld_n),
    .len_in     (len_in),
    .oe_n       (oe_n),
    .dout       (dout),
    .dout_valid (dout_valid),
    .wr_ptr     (wr_ptr),
    .lim_act    (lim_act)
);

// File: tb/line_delay_bench.sv
`timescale 1ns/1ps
module line_delay_bench;

    localparam int AW   = 5;
    localparam int DW   = 12;
    localparam int LMAX = (1 << AW) - 1;
    localparam int HM   = 32767;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] din;
    logic [AW-1:0] len_in;
    logic          len_ld_n, recirc, rst_wr_n, rst_rd_n, oe_n;
    logic [DW-1:0] dout;
    logic          dout_valid;

    int            cyc = 0;
    int            e0  = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;
    logic [DW-1:0] hist [0:HM];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    line_delay #(.ADDR_W(AW), .DATA_W(DW)) u_line_delay (
        .clk(clk), .rst_n(rst_n), .din(din), .len_in(len_in), .len_ld_n(len_ld_n),
        .recirc(recirc), .rst_wr_n(rst_wr_n), .rst_rd_n(rst_rd_n), .oe_n(oe_n),
        .dout(dout), .dout_valid(dout_valid)
    );

    function automatic logic [DW-1:0] gen(int n);
        return DW'((n * 29 + 7) ^ (n >> 2));
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic step();
        din = gen(cyc + 1);
        hist[(cyc + 1) & HM] = din;
        @(posedge clk);
        @(negedge clk);
    endtask

    // both pointer strobes low for one edge; lv on the length bus, ld selects a load
    task automatic sync(int lv, bit ld);
        len_in   = AW'(lv);
        len_ld_n = !ld;
        rst_wr_n = 1'b0;
        rst_rd_n = 1'b0;
        step();
        len_ld_n = 1'b1;
        rst_wr_n = 1'b1;
        rst_rd_n = 1'b1;
        e0 = cyc;
    endtask

    task automatic run(int lv, int cnt, string req);
        for (int k = 0; k < cnt; k++) begin
            int  n;
            bit  ev;
            step();
            n  = cyc;
            ev = (n >= e0 + lv + 2);
            chk(dout_valid == ev, (lv == 0 || lv == LMAX) ? "R9" : "R3", int'(dout_valid), int'(ev));
            if (ev) chk(dout == hist[(n - lv - 2) & HM], req, int'(dout), int'(hist[(n - lv - 2) & HM]));
            else    chk(dout == '0, "R8", int'(dout), 0);
        end
    endtask

    task automatic blank(int cnt, string req);
        for (int k = 0; k < cnt; k++) begin
            step();
            chk(dout_valid == 1'b0, req, int'(dout_valid), 0);
            chk(dout == '0, req, int'(dout), 0);
        end
    endtask

    task automatic loopchk(int lv);
        int t;
        recirc = 1'b1;
        t = cyc + 1;
        for (int j = 0; j < 3 * (lv + 1) + 2; j++) begin
            int n;
            int src;
            step();
            n   = cyc;
            src = t - lv - 2 + ((n - t) % (lv + 1));
            chk(dout_valid == 1'b1, "R5", int'(dout_valid), 1);
            chk(dout == hist[src & HM], "R5", int'(dout), int'(hist[src & HM]));
        end
        recirc = 1'b0;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; din = '0; len_in = '0; len_ld_n = 1'b1; recirc = 1'b0;
        rst_wr_n = 1'b1; rst_rd_n = 1'b1; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing valid before the first sync reset
        blank(6, "R1");

        // R2 R3 R9: sweep every length, load coinciding with the sync reset (R4)
        for (int lv = 0; lv <= LMAX; lv++) begin
            sync(lv, 1'b1);
            run(lv, 2 * (lv + 2) + 4, (lv == 0 || lv == LMAX) ? "R9" : "R2");
        end

        // R4: load without reset has no effect until a later sync reset
        sync(5, 1'b1);
        run(5, 12, "R4");
        len_in = AW'(9); len_ld_n = 1'b0;
        run(5, 1, "R4");
        len_ld_n = 1'b1;
        run(5, 15, "R4");
        sync(3, 1'b0);           // bus shows 3 but no load: staged 9 becomes active
        run(9, 25, "R4");

        // R8: output enable gates the word, not the flag
        oe_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk(dout == '0, "R8", int'(dout), 0);
            chk(dout_valid == 1'b1, "R8", int'(dout_valid), 1);
        end
        oe_n = 1'b0;
        run(9, 5, "R8");

        // R5 then R6: loop playback and leaving it without reset
        sync(4, 1'b1);
        run(4, 20, "R2");
        loopchk(4);
        blank(6, "R6");
        sync(0, 1'b1);
        run(0, 8, "R2");
        loopchk(0);
        blank(4, "R6");
        sync(7, 1'b1);
        run(7, 25, "R2");
        loopchk(7);
        blank(4, "R6");

        // R7: single-pointer resets
        sync(3, 1'b1);
        run(3, 10, "R2");
        rst_wr_n = 1'b0; step(); rst_wr_n = 1'b1;
        chk(dout_valid == 1'b0, "R7", int'(dout_valid), 0);
        blank(6, "R7");
        sync(3, 1'b1);
        run(3, 10, "R2");
        rst_rd_n = 1'b0; step(); rst_rd_n = 1'b1;
        chk(dout_valid == 1'b0, "R7", int'(dout_valid), 0);
        blank(6, "R7");

        // R10: recirculate raised during the fill
        sync(6, 1'b1);
        recirc = 1'b1;
        blank(3, "R10");
        recirc = 1'b0;
        blank(12, "R10");

        // recovery
        sync(2, 1'b1);
        run(2, 10, "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule